// File: doc/BRIEF.md
# Parallel ATA programmed-I/O cycle timing engine

This block carries out one programmed-I/O access on a parallel ATA device bus. A request names the direction, a 3-bit device register address, the two active-low chip-select values, 16-bit write data, and whether the access is an 8-bit register access or a 16-bit data access. The engine presents address and selects, waits a setup interval, and then pulses the read or write strobe low for the active interval. The active interval can be stretched by the device's IORDY flow-control line. The engine then waits out a recovery interval and reports completion along with the captured read data.

All interval lengths are counted in clock cycles and come from configuration inputs. Register and data accesses each have their own active, recovery and full-cycle values. The setup count and the write-data hold count are shared. The bus data pins are split into separate output, output-enable and input signals so that the pad cell can sit outside the block. The IORDY input is assumed to be synchronous to the clock. The configuration inputs are sampled once, when a request is accepted.

Top module: `pio_timing_engine`

## Requirements
- R1: After reset, and in every idle cycle, `ata_ctl` is 5'b00011 (both selects inactive, address zero), both strobes are high, `dd_oe` is 0, `req_ready` is 1, `done` is 0, and `timeout` is 0 after reset.
- R2: From the first setup cycle through the last recovery cycle, `ata_ctl` bits 4:2 carry the request address, bit 1 carries the CS1 value and bit 0 carries the CS0 value. Fields presented on the request port while the engine is busy have no effect on this.
- R3: After acceptance, both strobes stay high for exactly max(S,1) cycles, where S is `cfg_setup`.
- R4: In a read, only `dior_n` goes low and `dd_oe` stays 0. `rdata` takes the `dd_in` value sampled at the clock edge on which `dior_n` rises, and it is valid while `done` is high.
- R5: In a write, only `diow_n` goes low. `dd_oe` is 1 and `dd_out` equals the write data for every cycle that `diow_n` is low, and also for the first H recovery cycles, where H is `cfg_hold`.
- R6: With flow control disabled, the strobe stays low for exactly max(A,1) cycles, and IORDY has no effect.
- R7: With flow control enabled, the strobe stays low for E cycles. E is the first strobe-low cycle count e that satisfies all of the following: e ≥ max(A,1), e ≥ IORDY_DLY, and IORDY is high in that cycle. An IORDY high level seen earlier than IORDY_DLY cycles is not honoured.
- R8: With flow control enabled and IORDY never accepted, the strobe rises after IORDY_TMO low cycles (or after max(A,1) cycles if that is larger), and the sticky `timeout` output goes to 1. It then stays at 1 until reset. If IORDY is high in the limit cycle itself, `timeout` is not set.
- R9: Recovery (strobe high, selects still driven) lasts R cycles. R is C−E when C>E and C−E exceeds the minimum recovery V; otherwise R is V. R is raised to at least 1, and for writes it is also raised to at least H.
- R10: When `req_reg` is 1, A, V and C come from the 8-bit set (`cfg_act8`, `cfg_rec8`, `cfg_cyc8`). When `req_reg` is 0, they come from the 16-bit set.
- R11: `req_ready` is high only while idle, and a request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `done` is a single-cycle pulse in the cycle after the last recovery cycle, and `req_ready` is also high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_reg | input | 1 | 1 = 8-bit register timing set, 0 = 16-bit data set |
| req_addr | input | 3 | Device register address |
| req_cs1n | input | 1 | Value for CS1 (active low) |
| req_cs0n | input | 1 | Value for CS0 (active low) |
| req_wdata | input | 16 | Write data |
| cfg_setup | input | CNT_W | Setup cycles |
| cfg_act8 | input | CNT_W | Minimum strobe-low cycles, register set |
| cfg_rec8 | input | CNT_W | Minimum recovery cycles, register set |
| cfg_cyc8 | input | CNT_W | Minimum strobe-fall-to-end cycles, register set |
| cfg_act16 | input | CNT_W | Minimum strobe-low cycles, data set |
| cfg_rec16 | input | CNT_W | Minimum recovery cycles, data set |
| cfg_cyc16 | input | CNT_W | Minimum strobe-fall-to-end cycles, data set |
| cfg_hold | input | HOLD_W | Write-data hold cycles after the strobe rises |
| cfg_iordy_en | input | 1 | Enable IORDY flow control |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| timeout | output | 1 | Sticky IORDY timeout flag |
| ata_ctl | output | 5 | {A2..A0, CS1N, CS0N} |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Bus data out |
| dd_oe | output | 1 | Bus data output enable |
| dd_in | input | 16 | Bus data in |
| iordy | input | 1 | Device ready (flow control) |

## Verification
The IORDY release and the hard wait limit can land in the same strobe-low cycle. In that case the access must end with no timeout, because the device was ready. The bench provokes this by holding IORDY low and raising it exactly in strobe-low cycle IORDY_TMO. It judges the result by the strobe-low length (IORDY_TMO) and by `timeout` staying 0. A following access with IORDY never raised must then end at the same length and set the flag. The end of recovery also coincides with the point at which a new request can be accepted. So a request is held on the port throughout a busy access, and the bench checks that `ata_ctl` never takes the new fields before `done`.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_REC} pio_phase_t;
  // Idle control word: address zero, both selects inactive.
  localparam logic [4:0] CTL_IDLE = 5'b00011;
endpackage

// File: rtl/pio_tsel.sv
module pio_tsel #(
  parameter int CNT_W = 6
) (
  input  logic             sel_reg,
  input  logic [CNT_W-1:0] act8,
  input  logic [CNT_W-1:0] rec8,
  input  logic [CNT_W-1:0] cyc8,
  input  logic [CNT_W-1:0] act16,
  input  logic [CNT_W-1:0] rec16,
  input  logic [CNT_W-1:0] cyc16,
  output logic [CNT_W-1:0] act,
  output logic [CNT_W-1:0] rec,
  output logic [CNT_W-1:0] cyc
);
  always_comb begin
    if (sel_reg) begin
      act = act8;
      rec = rec8;
      cyc = cyc8;
    end else begin
      act = act16;
      rec = rec16;
      cyc = cyc16;
    end
  end
endmodule

// File: rtl/pio_seq.sv
module pio_seq
  import pio_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int HOLD_W    = 2,
  parameter int DW        = 16,
  parameter int IORDY_DLY = 2,
  parameter int IORDY_TMO = 65
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2:0]        req_addr,
  input  logic              req_cs1n,
  input  logic              req_cs0n,
  input  logic [DW-1:0]     req_wdata,
  input  logic [CNT_W-1:0]  sel_setup,
  input  logic [CNT_W-1:0]  sel_act,
  input  logic [CNT_W-1:0]  sel_rec,
  input  logic [CNT_W-1:0]  sel_cyc,
  input  logic [HOLD_W-1:0] sel_hold,
  input  logic              sel_ien,
  input  logic              iordy,
  input  logic [DW-1:0]     dd_in,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              timeout,
  output logic [4:0]        n_ctl,
  output logic              n_dior_n,
  output logic              n_diow_n,
  output logic              n_oe,
  output logic [DW-1:0]     n_dout
);
  localparam int LIM_W = $clog2(IORDY_TMO + 1);
  localparam int TW    = ((CNT_W > LIM_W) ? CNT_W : LIM_W) + 1;
  localparam logic [TW-1:0] DLY_T = TW'(IORDY_DLY);
  localparam logic [TW-1:0] TMO_T = TW'(IORDY_TMO);
  localparam logic [TW-1:0] ONE_T = TW'(1);

  pio_phase_t       st, st_n;
  logic [TW-1:0]    cnt, cnt_n, rlen, rlen_n;
  logic             done_n, tmo_set;
  logic             l_wr, l_ien;
  logic [4:0]       l_ctl;
  logic [DW-1:0]    l_wdata;
  logic [TW-1:0]    l_setup, l_act, l_rec, l_cyc, l_hold;

  function automatic logic [TW-1:0] at_least1(input logic [TW-1:0] v);
    return (v == '0) ? ONE_T : v;
  endfunction

  logic [TW-1:0] s_eff, a_eff, diff, rbase, rbase1, rec_len;
  logic          ior_ok, act_end, tmo_hit, accept;

  always_comb begin
    s_eff   = at_least1(l_setup);
    a_eff   = at_least1(l_act);
    ior_ok  = (cnt >= DLY_T) && iordy;
    act_end = (cnt >= a_eff) && (!l_ien || ior_ok || (cnt >= TMO_T));
    tmo_hit = l_ien && !ior_ok && (cnt >= TMO_T);
    diff    = l_cyc - cnt;
    rbase   = ((l_cyc > cnt) && (diff > l_rec)) ? diff : l_rec;
    rbase1  = at_least1(rbase);
    rec_len = (l_wr && (l_hold > rbase1)) ? l_hold : rbase1;
  end

  assign req_ready = (st == PH_IDLE);
  assign accept    = req_ready && req_valid;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    rlen_n  = rlen;
    done_n  = 1'b0;
    tmo_set = 1'b0;
    case (st)
      PH_IDLE: begin
        if (req_valid) begin
          st_n  = PH_SETUP;
          cnt_n = ONE_T;
        end
      end
      PH_SETUP: begin
        if (cnt >= s_eff) begin
          st_n  = PH_ACT;
          cnt_n = ONE_T;
        end else begin
          cnt_n = cnt + ONE_T;
        end
      end
      PH_ACT: begin
        if (act_end) begin
          st_n    = PH_REC;
          cnt_n   = ONE_T;
          rlen_n  = rec_len;
          tmo_set = tmo_hit;
        end else begin
          cnt_n = cnt + ONE_T;
        end
      end
      default: begin
        if (cnt >= rlen) begin
          st_n   = PH_IDLE;
          cnt_n  = '0;
          done_n = 1'b1;
        end else begin
          cnt_n = cnt + ONE_T;
        end
      end
    endcase
  end

  // Next-cycle pin values, registered by the pin stage.
  always_comb begin
    if (st_n == PH_IDLE)      n_ctl = CTL_IDLE;
    else if (st == PH_IDLE)   n_ctl = {req_addr, req_cs1n, req_cs0n};
    else                      n_ctl = l_ctl;
    n_dior_n = !((st_n == PH_ACT) && !l_wr);
    n_diow_n = !((st_n == PH_ACT) && l_wr);
    n_oe     = l_wr && ((st_n == PH_ACT) || ((st_n == PH_REC) && (cnt_n <= l_hold)));
    n_dout   = n_oe ? l_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PH_IDLE;
      cnt     <= '0;
      rlen    <= '0;
      done    <= 1'b0;
      timeout <= 1'b0;
      rdata   <= '0;
      l_wr    <= 1'b0;
      l_ien   <= 1'b0;
      l_ctl   <= CTL_IDLE;
      l_wdata <= '0;
      l_setup <= '0;
      l_act   <= '0;
      l_rec   <= '0;
      l_cyc   <= '0;
      l_hold  <= '0;
    end else begin
      st      <= st_n;
      cnt     <= cnt_n;
      rlen    <= rlen_n;
      done    <= done_n;
      timeout <= timeout | tmo_set;
      if (accept) begin
        l_wr    <= req_write;
        l_ien   <= sel_ien;
        l_ctl   <= {req_addr, req_cs1n, req_cs0n};
        l_wdata <= req_wdata;
        l_setup <= TW'(sel_setup);
        l_act   <= TW'(sel_act);
        l_rec   <= TW'(sel_rec);
        l_cyc   <= TW'(sel_cyc);
        l_hold  <= TW'(sel_hold);
      end
      if ((st == PH_ACT) && act_end && !l_wr) rdata <= dd_in;
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R8
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (rst) !$fell(timeout));
endmodule

// File: rtl/pio_pins.sv
module pio_pins
  import pio_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    n_ctl,
  input  logic          n_dior_n,
  input  logic          n_diow_n,
  input  logic          n_oe,
  input  logic [DW-1:0] n_dout,
  output logic [4:0]    ata_ctl,
  output logic          dior_n,
  output logic          diow_n,
  output logic          dd_oe,
  output logic [DW-1:0] dd_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ata_ctl <= CTL_IDLE;
      dior_n  <= 1'b1;
      diow_n  <= 1'b1;
      dd_oe   <= 1'b0;
      dd_out  <= '0;
    end else begin
      ata_ctl <= n_ctl;
      dior_n  <= n_dior_n;
      diow_n  <= n_diow_n;
      dd_oe   <= n_oe;
      dd_out  <= n_dout;
    end
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) dior_n || diow_n);
  // R5
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst) !diow_n |-> dd_oe);
  // R4
  rd_float_chk: assert property (@(posedge clk) disable iff (rst) !dior_n |-> !dd_oe);
endmodule

// File: rtl/pio_timing_engine.sv
module pio_timing_engine #(
  parameter int CNT_W     = 6,
  parameter int HOLD_W    = 2,
  parameter int DW        = 16,
  parameter int IORDY_DLY = 2,
  parameter int IORDY_TMO = 65
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_reg,
  input  logic [2:0]        req_addr,
  input  logic              req_cs1n,
  input  logic              req_cs0n,
  input  logic [DW-1:0]     req_wdata,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_act8,
  input  logic [CNT_W-1:0]  cfg_rec8,
  input  logic [CNT_W-1:0]  cfg_cyc8,
  input  logic [CNT_W-1:0]  cfg_act16,
  input  logic [CNT_W-1:0]  cfg_rec16,
  input  logic [CNT_W-1:0]  cfg_cyc16,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic              cfg_iordy_en,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              timeout,
  output logic [4:0]        ata_ctl,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DW-1:0]     dd_out,
  output logic              dd_oe,
  input  logic [DW-1:0]     dd_in,
  input  logic              iordy
);
  logic [CNT_W-1:0] s_act, s_rec, s_cyc;
  logic [4:0]       n_ctl;
  logic             n_dior_n, n_diow_n, n_oe;
  logic [DW-1:0]    n_dout;

  pio_tsel #(.CNT_W(CNT_W)) u_tsel (
    .sel_reg(req_reg),
    .act8(cfg_act8), .rec8(cfg_rec8), .cyc8(cfg_cyc8),
    .act16(cfg_act16), .rec16(cfg_rec16), .cyc16(cfg_cyc16),
    .act(s_act), .rec(s_rec), .cyc(s_cyc)
  );

  pio_seq #(
    .CNT_W(CNT_W), .HOLD_W(HOLD_W), .DW(DW),
    .IORDY_DLY(IORDY_DLY), .IORDY_TMO(IORDY_TMO)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr),
    .req_cs1n(req_cs1n), .req_cs0n(req_cs0n), .req_wdata(req_wdata),
    .sel_setup(cfg_setup), .sel_act(s_act), .sel_rec(s_rec), .sel_cyc(s_cyc),
    .sel_hold(cfg_hold), .sel_ien(cfg_iordy_en),
    .iordy(iordy), .dd_in(dd_in),
    .done(done), .rdata(rdata), .timeout(timeout),
    .n_ctl(n_ctl), .n_dior_n(n_dior_n), .n_diow_n(n_diow_n),
    .n_oe(n_oe), .n_dout(n_dout)
  );

  pio_pins #(.DW(DW)) u_pins (
    .clk(clk), .rst(rst),
    .n_ctl(n_ctl), .n_dior_n(n_dior_n), .n_diow_n(n_diow_n),
    .n_oe(n_oe), .n_dout(n_dout),
    .ata_ctl(ata_ctl), .dior_n(dior_n), .diow_n(diow_n),
    .dd_oe(dd_oe), .dd_out(dd_out)
  );
endmodule

// File: tb/sim_pio_timing_engine.sv
module sim_pio_timing_engine;
  localparam int CNT_W = 6;
  localparam int HW    = 2;
  localparam int DLY   = 2;
  localparam int TMO   = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_reg = 0, req_cs1n = 1, req_cs0n = 1;
  logic [2:0] req_addr = 0;
  logic [15:0] req_wdata = 0, dd_in = 0;
  logic [CNT_W-1:0] cfg_setup = 1, cfg_act8 = 1, cfg_rec8 = 1, cfg_cyc8 = 1;
  logic [CNT_W-1:0] cfg_act16 = 1, cfg_rec16 = 1, cfg_cyc16 = 1;
  logic [HW-1:0] cfg_hold = 0;
  logic cfg_iordy_en = 0, iordy = 1;
  logic req_ready, done, timeout, dior_n, diow_n, dd_oe;
  logic [15:0] rdata, dd_out;
  logic [4:0] ata_ctl;

  pio_timing_engine #(.CNT_W(CNT_W), .HOLD_W(HW), .DW(16), .IORDY_DLY(DLY), .IORDY_TMO(TMO)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_reg(req_reg), .req_addr(req_addr),
    .req_cs1n(req_cs1n), .req_cs0n(req_cs0n), .req_wdata(req_wdata),
    .cfg_setup(cfg_setup), .cfg_act8(cfg_act8), .cfg_rec8(cfg_rec8), .cfg_cyc8(cfg_cyc8),
    .cfg_act16(cfg_act16), .cfg_rec16(cfg_rec16), .cfg_cyc16(cfg_cyc16),
    .cfg_hold(cfg_hold), .cfg_iordy_en(cfg_iordy_en),
    .done(done), .rdata(rdata), .timeout(timeout), .ata_ctl(ata_ctl),
    .dior_n(dior_n), .diow_n(diow_n), .dd_out(dd_out), .dd_oe(dd_oe),
    .dd_in(dd_in), .iordy(iordy)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One access; expected phase lengths computed from the requirements.
  task automatic run(input bit wr, input bit isreg, input logic [2:0] addr,
                     input bit cs1, input bit cs0, input logic [15:0] wd,
                     input int s, input int a, input int r, input int c,
                     input int h, input bit ien, input int rel, input bit poke);
    int se, ae, e_exp, r_exp, base, ns, na, nr, bad_ctl, bad_oe, bad_stb, k;
    bit seen, exp_tmo;
    logic [4:0] word;
    se = (s < 1) ? 1 : s;
    ae = (a < 1) ? 1 : a;
    e_exp = 0;
    for (int e = 1; e < 200; e++) begin
      if (e >= ae && (!ien || (e >= DLY && e >= rel) || e >= TMO)) begin
        e_exp = e;
        break;
      end
    end
    exp_tmo = ien && !(e_exp >= DLY && e_exp >= rel);
    base = (c > e_exp && (c - e_exp) > r) ? (c - e_exp) : r;
    if (base < 1) base = 1;
    if (wr && h > base) base = h;
    r_exp = base;
    word = {addr, cs1, cs0};

    while (!req_ready) @(negedge clk);
    cfg_setup = CNT_W'(s);
    if (isreg) begin
      cfg_act8 = CNT_W'(a); cfg_rec8 = CNT_W'(r); cfg_cyc8 = CNT_W'(c);
      cfg_act16 = CNT_W'(a + 2); cfg_rec16 = CNT_W'(r + 3); cfg_cyc16 = CNT_W'(c + 5);
    end else begin
      cfg_act16 = CNT_W'(a); cfg_rec16 = CNT_W'(r); cfg_cyc16 = CNT_W'(c);
      cfg_act8 = CNT_W'(a + 2); cfg_rec8 = CNT_W'(r + 3); cfg_cyc8 = CNT_W'(c + 5);
    end
    cfg_hold = HW'(h);
    cfg_iordy_en = ien;
    req_write = wr; req_reg = isreg; req_addr = addr;
    req_cs1n = cs1; req_cs0n = cs0; req_wdata = wd;
    iordy = 1'b0; dd_in = 16'h0;
    req_valid = 1'b1;
    @(negedge clk);
    if (poke) begin
      req_addr = ~addr; req_cs1n = ~cs1; req_cs0n = ~cs0; req_wdata = ~wd;
      req_write = ~wr; req_reg = ~isreg;
    end else begin
      req_valid = 1'b0;
    end
    ns = 0; na = 0; nr = 0; bad_ctl = 0; bad_oe = 0; bad_stb = 0; seen = 0;
    for (k = 0; k < 500; k++) begin
      if (done) break;
      if (ata_ctl !== word || req_ready) bad_ctl++;
      if ((wr ? !diow_n : !dior_n)) begin
        na++; seen = 1;
        if ((wr ? dior_n : diow_n) !== 1'b1) bad_stb++;
        if (dd_oe !== wr || (wr && dd_out !== wd)) bad_oe++;
        iordy = (na >= rel);
        dd_in = wd ^ 16'(na);
      end else begin
        if (dior_n !== 1'b1 || diow_n !== 1'b1) bad_stb++;
        if (!seen) begin
          ns++;
          if (dd_oe !== 1'b0) bad_oe++;
        end else begin
          nr++;
          if (dd_oe !== (wr && nr <= h) || (dd_oe && dd_out !== wd)) bad_oe++;
        end
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    iordy = 1'b1;
    chk(done === 1'b1 && req_ready === 1'b1, "R11 done with ready", int'(done), 1);
    chk(ns == se, "R3 setup length", ns, se);
    chk(na == e_exp, ien ? "R7 active length with IORDY" : "R6 active length", na, e_exp);
    chk(nr == r_exp, isreg ? "R9 R10 recovery (8-bit set)" : "R9 R10 recovery (16-bit set)", nr, r_exp);
    chk(bad_ctl == 0, poke ? "R2 R11 control word under busy request" : "R2 control word", bad_ctl, 0);
    chk(bad_stb == 0, wr ? "R5 strobe selection" : "R4 strobe selection", bad_stb, 0);
    chk(bad_oe == 0, "R5 data drive window", bad_oe, 0);
    chk(ata_ctl === 5'b00011 && dior_n && diow_n && !dd_oe, "R1 idle pins after access",
        int'(ata_ctl), 3);
    if (!wr) chk(rdata === (wd ^ 16'(e_exp)), "R4 captured read data", int'(rdata),
                 int'(wd ^ 16'(e_exp)));
    if (ien && exp_tmo) chk(timeout === 1'b1, "R8 timeout set", int'(timeout), 1);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ata_ctl === 5'b00011, "R1 reset control word", int'(ata_ctl), 3);
    chk(dior_n === 1'b1 && diow_n === 1'b1 && dd_oe === 1'b0, "R1 reset strobes", int'(dior_n), 1);
    chk(req_ready === 1'b1 && done === 1'b0 && timeout === 1'b0, "R1 reset status", int'(req_ready), 1);

    // Sweep: timing sets, direction, register/data selection; IORDY held low but disabled.
    for (int s = 0; s <= 3; s++)
      for (int a = 1; a <= 3; a += 2)
        for (int c = 1; c <= 9; c += 8)
          for (int r = 1; r <= 4; r += 3)
            for (int m = 0; m < 4; m++)
              run(m[0], m[1], 3'(s + a + m), 1'b0, 1'b1,
                  16'(16'h5A31 + 16'(s * 97 + a * 13 + c * 7 + r + m * 1000)),
                  s, a, r, c, (s + m) % 4, 1'b0, 1000, 1'b0);

    // Write-data hold longer than recovery (R5, R9).
    run(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, 16'hBEEF, 1, 1, 1, 1, 3, 1'b0, 1000, 1'b0);
    // Control register access through CS0 at address 6 (R2).
    run(1'b1, 1'b1, 3'd6, 1'b1, 1'b0, 16'h0008, 2, 2, 2, 5, 1, 1'b0, 1000, 1'b0);
    // Request held and changed while busy (R11, R2).
    run(1'b0, 1'b1, 3'd7, 1'b0, 1'b1, 16'h1234, 2, 3, 2, 4, 0, 1'b0, 1000, 1'b1);

    // IORDY flow control (R7): early-high ignored before the sampling delay.
    run(1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 16'h7700, 1, 1, 1, 1, 0, 1'b1, 0, 1'b0);
    run(1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 16'h7701, 1, 2, 1, 4, 0, 1'b1, 5, 1'b0);
    run(1'b1, 1'b1, 3'd2, 1'b0, 1'b1, 16'h7702, 1, 6, 2, 3, 2, 1'b1, 3, 1'b0);
    // Release in the limit cycle: no timeout (R8).
    run(1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 16'h7703, 1, 1, 1, 1, 0, 1'b1, TMO, 1'b0);
    chk(timeout === 1'b0, "R8 no timeout when ready in limit cycle", int'(timeout), 0);
    // Never ready: timeout (R8).
    run(1'b0, 1'b0, 3'd1, 1'b0, 1'b1, 16'h7704, 1, 1, 1, 1, 0, 1'b1, 1000, 1'b0);
    run(1'b1, 1'b0, 3'd3, 1'b0, 1'b1, 16'h7705, 1, 2, 1, 1, 1, 1'b0, 1000, 1'b0);
    chk(timeout === 1'b1, "R8 timeout stays set", int'(timeout), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule